// File: doc/BRIEF.md
# Two-Beat Split-Port Byte-Masked SRAM

This block is an on-chip memory with an independent read port and write port on one clock. Every command on either port moves a pair of data words, called beats, that sit at adjacent word locations: beat 1 at word `{base,0}` and beat 2 at word `{base,1}`. Data is organised in 9-bit bytes.

A write is spread over two clock edges. The edge that sees the active-low write strobe also takes the first data beat and its active-low byte masks. The next edge takes the base address, the second data beat and its masks. Bytes whose mask bit is high keep the value they held before.

A read is issued in one cycle with an active-low strobe and a base address. The two beats come back on a registered output after a fixed latency, each one flagged by `rd_valid`. A compile-time option returns freshly merged data when a read hits a row that is being committed on the same edge.

Top module: `burst2_sram`

## Requirements
- R1: During and right after synchronous reset `rd_valid` is low, and neither port has a command in progress.
- R2: `rd_n` low at edge N, with the port free, reads base `rd_addr`. Word `{base,0}` appears on `rd_data` with `rd_valid` high after edge N+RD_LAT, and word `{base,1}` after edge N+RD_LAT+1. `rd_valid` is low in the cycle before these two beats and, unless another read follows, in the cycle after them.
- R3: `rd_n` high at an edge starts no read, and `rd_valid` stays low.
- R4: `wr_n` low at edge N, with the port free, captures `wr_data` and `wr_be_n` as beat 1. Edge N+1 captures `wr_addr`, beat 2 data and beat 2 masks, and both beats are stored at that base.
- R5: Bit k of `wr_be_n` high leaves data bits 9k..9k+8 of that beat's word unchanged. Bit 0 guards bits 8..0 and bit 1 guards bits 17..9.
- R6: The masks of beat 1 and beat 2 are independent, and any combination is allowed, including all bytes blocked.
- R7: `wr_n` high at an edge where the write port is free starts no write, whatever is on `wr_addr`, `wr_data` and `wr_be_n`.
- R8: Each port accepts at most one command per two cycles. `rd_n` low at the edge right after an accepted read is ignored. At the edge right after an accepted write, `wr_n` is ignored because that edge carries beat 2.
- R9: With the bypass option on (the default), a read accepted on the edge where a write commits the same base returns the newly merged beats.
- R10: A read accepted on the edge that captures a write command for the same base returns the old contents.
- R11: Commands can be issued every second cycle on both ports at once. Back-to-back reads give an unbroken run of valid beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read command strobe |
| rd_addr | input | AW | Read base address |
| rd_data | output | NB*9 | Registered read beat |
| rd_valid | output | 1 | High while `rd_data` holds a beat |
| wr_n | input | 1 | Active-low write command strobe |
| wr_addr | input | AW | Write base address, taken one edge after the command |
| wr_data | input | NB*9 | Write beat data |
| wr_be_n | input | NB | Active-low byte masks for the current beat |

## Verification
The hardest case to reach is a read that lands on exactly the edge where a write to the same base commits, which is the edge after the write command. The bench reaches it by driving the write's second beat and the read strobe in the same cycle, with a partial mask so that the merge is visible. It also places a read on the command edge of a write to show that old data comes back. Ignored strobes are tested by holding `rd_n` and `wr_n` low across two edges and then reading back the rows a wrongly accepted command would have touched.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  localparam int BYTE_W = 9;

  typedef enum logic {
    WR_IDLE  = 1'b0,
    WR_BEAT2 = 1'b1
  } wr_phase_e;
endpackage

// File: rtl/burst2_wr_ctl.sv
module burst2_wr_ctl
  import burst2_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_n,
  input  logic [AW-1:0]            wr_addr,
  input  logic [NB*BYTE_W-1:0]     wr_data,
  input  logic [NB-1:0]            wr_be_n,
  output logic                     row_we,
  output logic [AW-1:0]            row_addr,
  output logic [2*NB*BYTE_W-1:0]   row_data,
  output logic [2*NB-1:0]          row_lane
);
  localparam int DW = NB * BYTE_W;

  wr_phase_e         phase;
  logic [DW-1:0]     b1_data;
  logic [NB-1:0]     b1_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= WR_IDLE;
    end else begin
      case (phase)
        WR_IDLE:  if (!wr_n) phase <= WR_BEAT2;
        WR_BEAT2: phase <= WR_IDLE;
        default:  phase <= WR_IDLE;
      endcase
    end
  end

  // beat 1 is held until its base address arrives
  always_ff @(posedge clk) begin
    if (phase == WR_IDLE && !wr_n) begin
      b1_data <= wr_data;
      b1_en   <= ~wr_be_n;
    end
  end

  // the whole two-beat row commits on the address edge
  assign row_we   = (phase == WR_BEAT2);
  assign row_addr = wr_addr;
  assign row_data = {wr_data, b1_data};
  assign row_lane = {~wr_be_n, b1_en};
endmodule

// File: rtl/burst2_array.sv
module burst2_array
  import burst2_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [LANES*BYTE_W-1:0]     wdata,
  input  logic [LANES-1:0]            wlane,
  input  logic                        re,
  input  logic [AW-1:0]               raddr,
  output logic [LANES*BYTE_W-1:0]     rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int RW    = LANES * BYTE_W;

  logic [RW-1:0] mem [DEPTH];

  // byte-lane write enables, read-first registered port
  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wlane[l]) mem[waddr][l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
      end
    end
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/burst2_rd_ctl.sv
module burst2_rd_ctl
  import burst2_pkg::*;
#(
  parameter int AW     = 6,
  parameter int NB     = 2,
  parameter int RD_LAT = 2,
  parameter bit BYPASS = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_n,
  input  logic [AW-1:0]            rd_addr,
  input  logic                     wr_we,
  input  logic [AW-1:0]            wr_addr,
  input  logic [2*NB*BYTE_W-1:0]   wr_row,
  input  logic [2*NB-1:0]          wr_lane,
  input  logic [2*NB*BYTE_W-1:0]   arr_row,
  output logic                     arr_re,
  output logic [AW-1:0]            arr_addr,
  output logic                     rd_go,
  output logic [NB*BYTE_W-1:0]     rd_data,
  output logic                     rd_valid
);
  localparam int DW    = NB * BYTE_W;
  localparam int LANES = 2 * NB;
  localparam int RW    = LANES * BYTE_W;

  logic          busy;
  logic          go_q;
  logic [RW-1:0] row_eff;
  logic [RW-1:0] tap_row;
  logic          tap_v;
  logic [DW-1:0] beat2_hold;
  logic          beat2_pend;

  assign rd_go    = !rd_n && !busy;
  assign arr_re   = rd_go;
  assign arr_addr = rd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      go_q <= 1'b0;
    end else begin
      busy <= rd_go;
      go_q <= rd_go;
    end
  end

  generate
    if (BYPASS) begin : g_byp
      logic             hit_q;
      logic [RW-1:0]    byp_row_q;
      logic [LANES-1:0] byp_lane_q;

      always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= rd_go && wr_we && (wr_addr == rd_addr);
      end

      always_ff @(posedge clk) begin
        if (rd_go) begin
          byp_row_q  <= wr_row;
          byp_lane_q <= wr_lane;
        end
      end

      always_comb begin
        for (int l = 0; l < LANES; l++) begin
          row_eff[l*BYTE_W +: BYTE_W] = (hit_q && byp_lane_q[l])
                                        ? byp_row_q[l*BYTE_W +: BYTE_W]
                                        : arr_row[l*BYTE_W +: BYTE_W];
        end
      end
    end else begin : g_nobyp
      assign row_eff = arr_row;
    end
  endgenerate

  generate
    if (RD_LAT <= 1) begin : g_lat1
      assign tap_row = row_eff;
      assign tap_v   = go_q;
    end else begin : g_dly
      logic [RW-1:0]     dl_row [RD_LAT-1];
      logic [RD_LAT-2:0] dl_v;

      always_ff @(posedge clk) begin
        if (rst) begin
          dl_v <= '0;
        end else begin
          dl_v[0] <= go_q;
          for (int k = 1; k < RD_LAT-1; k++) dl_v[k] <= dl_v[k-1];
        end
      end

      always_ff @(posedge clk) begin
        dl_row[0] <= row_eff;
        for (int k = 1; k < RD_LAT-1; k++) dl_row[k] <= dl_row[k-1];
      end

      assign tap_row = dl_row[RD_LAT-2];
      assign tap_v   = dl_v[RD_LAT-2];
    end
  endgenerate

  // serialise the row: beat 1 then beat 2
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      beat2_pend <= 1'b0;
    end else if (tap_v) begin
      rd_data    <= tap_row[DW-1:0];
      beat2_hold <= tap_row[DW +: DW];
      rd_valid   <= 1'b1;
      beat2_pend <= 1'b1;
    end else if (beat2_pend) begin
      rd_data    <= beat2_hold;
      rd_valid   <= 1'b1;
      beat2_pend <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
  import burst2_pkg::*;
#(
  parameter int AW     = 6,
  parameter int NB     = 2,
  parameter int RD_LAT = 2,
  parameter bit BYPASS = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_n,
  input  logic [AW-1:0]         rd_addr,
  output logic [NB*BYTE_W-1:0]  rd_data,
  output logic                  rd_valid,
  input  logic                  wr_n,
  input  logic [AW-1:0]         wr_addr,
  input  logic [NB*BYTE_W-1:0]  wr_data,
  input  logic [NB-1:0]         wr_be_n
);
  localparam int LANES = 2 * NB;
  localparam int RW    = LANES * BYTE_W;

  logic             wr_we;
  logic [AW-1:0]    wr_row_addr;
  logic [RW-1:0]    wr_row;
  logic [LANES-1:0] wr_lane;
  logic             arr_re;
  logic [AW-1:0]    arr_addr;
  logic [RW-1:0]    arr_row;
  logic             rd_go;

  burst2_wr_ctl #(.AW(AW), .NB(NB)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .wr_n     (wr_n),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be_n  (wr_be_n),
    .row_we   (wr_we),
    .row_addr (wr_row_addr),
    .row_data (wr_row),
    .row_lane (wr_lane)
  );

  burst2_array #(.AW(AW), .LANES(LANES)) u_mem (
    .clk   (clk),
    .we    (wr_we),
    .waddr (wr_row_addr),
    .wdata (wr_row),
    .wlane (wr_lane),
    .re    (arr_re),
    .raddr (arr_addr),
    .rdata (arr_row)
  );

  burst2_rd_ctl #(.AW(AW), .NB(NB), .RD_LAT(RD_LAT), .BYPASS(BYPASS)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_n     (rd_n),
    .rd_addr  (rd_addr),
    .wr_we    (wr_we),
    .wr_addr  (wr_row_addr),
    .wr_row   (wr_row),
    .wr_lane  (wr_lane),
    .arr_row  (arr_row),
    .arr_re   (arr_re),
    .arr_addr (arr_addr),
    .rd_go    (rd_go),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk #(
  parameter int RD_LAT = 2
) (
  input logic clk,
  input logic rst,
  input logic rd_n,
  input logic wr_n,
  input logic rd_valid,
  input logic rd_go,
  input logic wr_we
);
  logic [RD_LAT+1:0] sh;
  logic              c_wbusy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      c_wbusy <= 1'b0;
    end else begin
      sh      <= {sh[RD_LAT:0], rd_go};
      c_wbusy <= !c_wbusy && !wr_n;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!rd_valid && !wr_we));

  a_r2_valid_window: assert property (@(posedge clk) disable iff (rst)
    rd_valid == (sh[RD_LAT] || sh[RD_LAT+1]));

  a_r3_no_read_when_high: assert property (@(posedge clk) disable iff (rst)
    rd_n |-> !rd_go);

  a_r8_read_gap: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> !rd_go);

  a_r8_write_gap: assert property (@(posedge clk) disable iff (rst)
    wr_we |=> !wr_we);

  a_r4_commit_after_cmd: assert property (@(posedge clk) disable iff (rst)
    wr_we |-> $past(!wr_n && !c_wbusy));

  a_r7_wr_deselect: assert property (@(posedge clk) disable iff (rst)
    (wr_n && !c_wbusy) |=> !wr_we);
endmodule

bind burst2_sram burst2_sram_chk #(.RD_LAT(RD_LAT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .rd_valid (rd_valid),
  .rd_go    (rd_go),
  .wr_we    (wr_we)
);

// File: tb/burst2_sram_test.sv
`timescale 1ns/1ps
module burst2_sram_test;
  localparam int AW  = 6;
  localparam int NB  = 2;
  localparam int DW  = 18;
  localparam int LAT = 2;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d1;
    logic [NB-1:0] m1;
    logic [DW-1:0] d2;
    logic [NB-1:0] m2;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{a: 6'd3,  d1: 18'h0A5A5, m1: 2'b00, d2: 18'h35A5A, m2: 2'b00},
    '{a: 6'd3,  d1: 18'h3FFFF, m1: 2'b01, d2: 18'h00000, m2: 2'b10},
    '{a: 6'd9,  d1: 18'h12345, m1: 2'b00, d2: 18'h2ABCD, m2: 2'b00},
    '{a: 6'd9,  d1: 18'h00001, m1: 2'b11, d2: 18'h3FE00, m2: 2'b00},
    '{a: 6'd63, d1: 18'h1FFFF, m1: 2'b00, d2: 18'h2AAAA, m2: 2'b00},
    '{a: 6'd0,  d1: 18'h15555, m1: 2'b00, d2: 18'h0F0F0, m2: 2'b10}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          wr_n = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_be_n = '1;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  logic [DW-1:0] mdl [2**(AW+1)];
  logic [DW-1:0] e1, e2;

  always #2.5 clk = ~clk;

  burst2_sram #(.AW(AW), .NB(NB), .RD_LAT(LAT), .BYPASS(1'b1)) uut (
    .clk(clk), .rst(rst), .rd_n(rd_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be_n(wr_be_n)
  );

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NB-1:0] m);
    logic [DW-1:0] r = old_w;
    for (int k = 0; k < NB; k++) if (!m[k]) r[k*9 +: 9] = new_w[k*9 +: 9];
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr_burst(logic [AW-1:0] a, logic [DW-1:0] d1, logic [NB-1:0] m1,
                          logic [DW-1:0] d2, logic [NB-1:0] m2);
    @(negedge clk);
    wr_n = 1'b0; wr_data = d1; wr_be_n = m1;
    @(negedge clk);
    wr_n = 1'b1; wr_addr = a; wr_data = d2; wr_be_n = m2;
    mdl[{a, 1'b0}] = merge(mdl[{a, 1'b0}], d1, m1);
    mdl[{a, 1'b1}] = merge(mdl[{a, 1'b1}], d2, m2);
  endtask

  // read one base and compare both beats and the valid window (R2)
  task automatic rd_burst(logic [AW-1:0] a, string req);
    @(negedge clk);
    rd_n = 1'b0; rd_addr = a;
    @(negedge clk);
    rd_n = 1'b1;
    repeat (LAT-1) @(negedge clk);
    chk("R2 valid low before beat 1", {17'd0, rd_valid}, 18'd0);
    @(negedge clk);
    chk("R2 valid on beat 1", {17'd0, rd_valid}, 18'd1);
    chk(req, rd_data, mdl[{a, 1'b0}]);
    @(negedge clk);
    chk("R2 valid on beat 2", {17'd0, rd_valid}, 18'd1);
    chk(req, rd_data, mdl[{a, 1'b1}]);
    @(negedge clk);
    chk("R2 valid low after beat 2", {17'd0, rd_valid}, 18'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    // R1: reset holds the block quiet even with strobes low
    rd_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 valid during reset", {17'd0, rd_valid}, 18'd0);
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", {17'd0, rd_valid}, 18'd0);

    // clear every row so the model is fully known (R4)
    for (int a = 0; a < 2**AW; a++) wr_burst(a[AW-1:0], '0, '0, '0, '0);
    rd_burst(6'd17, "R4 cleared row");

    // vector table: write then read back
    for (int i = 0; i < 6; i++) begin
      wr_burst(VECS[i].a, VECS[i].d1, VECS[i].m1, VECS[i].d2, VECS[i].m2);
      if (VECS[i].m1 == 2'b00 && VECS[i].m2 == 2'b00) rd_burst(VECS[i].a, "R4 full write");
      else rd_burst(VECS[i].a, "R5/R6 masked write");
    end

    // R3: deselected read port produces nothing
    rd_n = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R3 no valid when deselected", {17'd0, rd_valid}, 18'd0);
    end

    // R7: write deselect with live address/data leaves row 14 untouched
    @(negedge clk);
    wr_n = 1'b1; wr_addr = 6'd14; wr_data = 18'h3FFFF; wr_be_n = 2'b00;
    repeat (4) @(negedge clk);
    rd_burst(6'd14, "R7 deselected write stored nothing");

    // R8: strobes held low across two edges
    @(negedge clk);
    rd_n = 1'b0; rd_addr = 6'd9;
    wr_n = 1'b0; wr_data = 18'h0BEEF; wr_be_n = 2'b00;
    @(negedge clk);                       // after E0
    rd_addr = 6'd3;
    wr_addr = 6'd12; wr_data = 18'h1CAFE;
    @(negedge clk);                       // after E1
    rd_n = 1'b1; wr_n = 1'b1;
    wr_addr = 6'd13; wr_data = 18'h3FFFF;
    mdl[{6'd12, 1'b0}] = 18'h0BEEF;
    mdl[{6'd12, 1'b1}] = 18'h1CAFE;
    @(negedge clk);                       // after E2
    chk("R8 read beat 1", rd_data, mdl[{6'd9, 1'b0}]);
    @(negedge clk);
    chk("R8 read beat 2", rd_data, mdl[{6'd9, 1'b1}]);
    @(negedge clk);
    chk("R8 second read strobe ignored", {17'd0, rd_valid}, 18'd0);
    rd_burst(6'd13, "R8 second write strobe ignored");
    rd_burst(6'd12, "R8 write held over two edges");

    // R9: read on the commit edge of a write to the same base
    @(negedge clk);
    wr_n = 1'b0; wr_data = 18'h11111; wr_be_n = 2'b00;
    @(negedge clk);
    wr_n = 1'b1; wr_addr = 6'd5; wr_data = 18'h22222; wr_be_n = 2'b01;
    rd_n = 1'b0; rd_addr = 6'd5;
    mdl[{6'd5, 1'b0}] = merge(mdl[{6'd5, 1'b0}], 18'h11111, 2'b00);
    mdl[{6'd5, 1'b1}] = merge(mdl[{6'd5, 1'b1}], 18'h22222, 2'b01);
    @(negedge clk);
    rd_n = 1'b1;
    repeat (LAT) @(negedge clk);
    chk("R9 bypass beat 1", rd_data, mdl[{6'd5, 1'b0}]);
    @(negedge clk);
    chk("R9 bypass beat 2", rd_data, mdl[{6'd5, 1'b1}]);

    // R10: read on the command edge returns old data
    e1 = mdl[{6'd6, 1'b0}];
    e2 = mdl[{6'd6, 1'b1}];
    @(negedge clk);
    wr_n = 1'b0; wr_data = 18'h2D2D2; wr_be_n = 2'b00;
    rd_n = 1'b0; rd_addr = 6'd6;
    @(negedge clk);
    wr_n = 1'b1; wr_addr = 6'd6; wr_data = 18'h34343; wr_be_n = 2'b00;
    rd_n = 1'b1;
    mdl[{6'd6, 1'b0}] = 18'h2D2D2;
    mdl[{6'd6, 1'b1}] = 18'h34343;
    repeat (LAT) @(negedge clk);
    chk("R10 old beat 1", rd_data, e1);
    @(negedge clk);
    chk("R10 old beat 2", rd_data, e2);
    rd_burst(6'd6, "R10 new data afterwards");

    // R11: both ports every second cycle
    @(negedge clk);
    wr_n = 1'b0; wr_data = 18'h0A0A0; wr_be_n = 2'b00;
    rd_n = 1'b0; rd_addr = 6'd3;
    @(negedge clk);                       // after E0
    wr_n = 1'b1; wr_addr = 6'd10; wr_data = 18'h0B0B0;
    rd_n = 1'b1;
    @(negedge clk);                       // after E1
    wr_n = 1'b0; wr_data = 18'h0C0C0;
    rd_n = 1'b0; rd_addr = 6'd9;
    @(negedge clk);                       // after E2
    wr_n = 1'b1; wr_addr = 6'd11; wr_data = 18'h0D0D0;
    rd_n = 1'b1;
    chk("R11 first read beat 1", rd_data, mdl[{6'd3, 1'b0}]);
    @(negedge clk);                       // after E3
    chk("R11 first read beat 2", rd_data, mdl[{6'd3, 1'b1}]);
    @(negedge clk);                       // after E4
    chk("R11 unbroken valid", {17'd0, rd_valid}, 18'd1);
    chk("R11 second read beat 1", rd_data, mdl[{6'd9, 1'b0}]);
    @(negedge clk);
    chk("R11 second read beat 2", rd_data, mdl[{6'd9, 1'b1}]);
    mdl[{6'd10, 1'b0}] = 18'h0A0A0; mdl[{6'd10, 1'b1}] = 18'h0B0B0;
    mdl[{6'd11, 1'b0}] = 18'h0C0C0; mdl[{6'd11, 1'b1}] = 18'h0D0D0;
    rd_burst(6'd10, "R11 first back-to-back write");
    rd_burst(6'd11, "R11 second back-to-back write");

    // R1: reset mid-read suppresses the pending beats
    @(negedge clk);
    rd_n = 1'b0; rd_addr = 6'd3;
    @(negedge clk);
    rd_n = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset drops pending read", {17'd0, rd_valid}, 18'd0);
    end

    report();
  end
endmodule